// File: doc/BRIEF.md
# Strobe-Ordered Single-Bit Memory Sequencer

This block decodes commands for a byte-wide memory that a host reaches through a single bit of its data bus. There is no serial clock and no select line. Each ordinary host bus access carries one bit. An access with chip-enable and write-enable low delivers a bit to the block. An access with chip-enable and output-enable low returns a bit to the host. The block finds commands only from the order of these accesses.

A read, a write carrying 0 and then another read form a restart pattern. The block then collects a 16-bit address, most significant bit first. After that, the first access decides the mode. Reads stream bytes out of the array, most significant bit first, and the address counts up. Writes load bytes toward a page-write controller. Repeating the restart pattern after whole bytes have been loaded asks that controller to commit the page. Out-of-order access patterns drop the block to idle. The three bus strobes and the data bit cross into the system clock through two-flop synchronizers. Cycle boundaries come from edges of the decoded strobes.

The array is outside the block. It shows up as an address output and a combinational read-data input, plus a byte-load strobe and a commit request. The page-write controller reports back through a busy input.

Top module: `strobe_bit_seq`

## Requirements
- R1: After reset, with no access in progress, `bus_dout_en` is 0. A read access returns 1.
- R2: `bus_dout_en` is 1 exactly while `bus_cs_n` and `bus_rd_n` are both low. It is 0 during a write access and while chip-enable is high.
- R3: A read, a write carrying 0 and a read, in that order, restart address collection from any state. Except during a sequential read, a read that follows the restart returns 1.
- R4: After the restart, 16 write accesses load the address, most significant bit first. The next 8 read accesses return the array byte at that address, bit 7 first.
- R5: After every 8th read the address increments, and 0x3FFF is followed by 0x0000. The reads continue without a new address.
- R6: If either of address bits 15:14 is 1, the array is not selected. Reads return 1 and no byte-load strobe is issued.
- R7: A write carrying 1 after a read inside a sequential read ends the stream. The following read returns 1.
- R8: The block drops to idle on each of these patterns. A read followed by two writes. A read followed by a write of 1 during address or data loading. Two reads followed by a write during data loading.
- R9: An access with chip-enable, output-enable and write-enable all low forces idle.
- R10: During loading, every 8 write bits form a byte, most significant bit first. Each byte produces a one-cycle `pg_we` pulse carrying its address and data. The byte offset within the 32-byte page (address bits 4:0) increments and wraps within the page.
- R11: The restart pattern issues a single one-cycle `commit_req` and enters idle only when two conditions hold. At least one complete byte has been loaded. The first read of the pattern falls on a byte boundary. Otherwise the pattern acts as a plain restart.
- R12: Outside a sequential read, a read access returns the inverse of `commit_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the host bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip-enable, active low, asynchronous |
| bus_rd_n | input | 1 | Host output-enable, active low, asynchronous |
| bus_wr_n | input | 1 | Host write-enable, active low, asynchronous |
| bus_din | input | 1 | Serial bit from the host data line |
| bus_dout | output | 1 | Serial bit toward the host data line |
| bus_dout_en | output | 1 | Drive enable for the host data line |
| arr_addr | output | 16 | Current byte address toward the array |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| pg_we | output | 1 | One-cycle strobe, a loaded byte is ready |
| pg_addr | output | 16 | Address of the loaded byte |
| pg_data | output | 8 | Value of the loaded byte |
| commit_req | output | 1 | One-cycle request to commit the loaded page |
| commit_busy | input | 1 | Page-write controller is committing |

## Verification
The embedded properties check several things on every cycle. A three-strobe collision always leaves the sequencer idle. Address collection always starts from bit zero. A completed read byte always advances the low address bits by one. Load strobes and commit requests are single pulses, and load strobes appear only from the loading state with array-selecting addresses. Other behaviour shows only over whole access sequences, so only the bench scenarios can show it. This includes the byte values streamed across the 0x3FFF wrap, the page-offset wrap of loaded bytes, and a partial or empty load that must not commit. It also includes the restart taking effect in the middle of a read, and the illegal patterns that must leave the next read returning 1.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,   // waiting for a restart pattern
    ST_ADDR  = 3'd1,   // collecting address bits
    ST_SEL   = 3'd2,   // address complete, mode not yet chosen
    ST_RDATA = 3'd3,   // streaming array bytes out
    ST_WDATA = 3'd4    // loading bytes toward the page writer
  } seq_state_t;

endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/bcs_cycle_decode.sv
module bcs_cycle_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic din,
  output logic ev_rd,
  output logic ev_wr,
  output logic ev_bit,
  output logic ev_bad
);

  logic wr_act, rd_act, bad_act;
  logic wr_q, rd_q, bad_q, bit_q;

  // Access classification on synchronized levels
  always_comb begin
    wr_act  = !cs_n && !wr_n &&  rd_n;
    rd_act  = !cs_n && !rd_n &&  wr_n;
    bad_act = !cs_n && !rd_n && !wr_n;
  end

  // Access ends when its decoded strobe falls (first strobe to rise)
  always_comb begin
    ev_wr  = wr_q && !wr_act && !bad_act;
    ev_rd  = rd_q && !rd_act && !bad_act;
    ev_bad = bad_act && !bad_q;
    ev_bit = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      bad_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      wr_q  <= wr_act;
      rd_q  <= rd_act;
      bad_q <= bad_act;
      if (wr_act) bit_q <= din;
    end
  end

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ARR_AW  = 14,
  parameter int PAGE_AW = 5,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd,
  input  logic              ev_wr,
  input  logic              ev_bit,
  input  logic              ev_bad,
  input  logic [BYTE_W-1:0] arr_rdata,
  input  logic              commit_busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              dout,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [BYTE_W-1:0] pg_data,
  output logic              commit_req
);

  localparam int ACNT_W = $clog2(ADDR_W);
  localparam int BCNT_W = $clog2(BYTE_W);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_W - 1);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(BYTE_W - 1);

  seq_state_t        state, n_state;
  logic [ADDR_W-1:0] addr, n_addr;
  logic [ACNT_W-1:0] acnt, n_acnt;
  logic [BCNT_W-1:0] bitcnt, n_bitcnt;
  logic [BYTE_W-2:0] byte_sh, n_byte;
  logic              have_byte, n_have;
  logic              last_r, n_last_r;   // previous access was a read
  logic              rw0, n_rw0;         // previous two: read, write 0
  logic              rr, n_rr;           // previous two: read, read
  logic              elig, n_elig;       // commit allowed if pattern completes
  logic              n_pg_we, n_commit;
  logic [ADDR_W-1:0] n_pg_addr;
  logic [BYTE_W-1:0] n_pg_data;
  logic              sel_ok;
  logic [BYTE_W-1:0] rd_shift;

  assign sel_ok   = (addr[ADDR_W-1:ARR_AW] == '0);
  assign arr_addr = addr;
  assign rd_shift = arr_rdata << bitcnt;

  // Serial output value
  always_comb begin
    if ((state == ST_SEL || state == ST_RDATA) && !rw0)
      dout = sel_ok ? rd_shift[BYTE_W-1] : 1'b1;
    else
      dout = !commit_busy;
  end

  // Next-state logic
  always_comb begin
    n_state   = state;
    n_addr    = addr;
    n_acnt    = acnt;
    n_bitcnt  = bitcnt;
    n_byte    = byte_sh;
    n_have    = have_byte;
    n_last_r  = last_r;
    n_rw0     = rw0;
    n_rr      = rr;
    n_elig    = elig;
    n_pg_we   = 1'b0;
    n_pg_addr = pg_addr;
    n_pg_data = pg_data;
    n_commit  = 1'b0;

    if (ev_bad) begin
      n_state  = ST_IDLE;
      n_last_r = 1'b0;
      n_rw0    = 1'b0;
      n_rr     = 1'b0;
      n_elig   = 1'b0;
    end else if (ev_rd) begin
      if (rw0) begin
        n_last_r = 1'b0;
        n_rw0    = 1'b0;
        n_rr     = 1'b0;
        n_elig   = 1'b0;
        if (state == ST_WDATA && elig) begin
          n_state  = ST_IDLE;
          n_commit = 1'b1;
        end else begin
          n_state = ST_ADDR;
          n_acnt  = '0;
        end
      end else begin
        n_rr     = last_r;
        n_last_r = 1'b1;
        case (state)
          ST_SEL, ST_RDATA: begin
            n_state = ST_RDATA;
            if (bitcnt == BCNT_LAST) begin
              n_bitcnt = '0;
              n_addr   = {addr[ADDR_W-1:ARR_AW], addr[ARR_AW-1:0] + 1'b1};
            end else begin
              n_bitcnt = bitcnt + 1'b1;
            end
          end
          ST_WDATA: begin
            if (!last_r) n_elig = (bitcnt == '0) && have_byte;
          end
          default: ;
        endcase
      end
    end else if (ev_wr) begin
      if (rw0) begin
        n_state  = ST_IDLE;
        n_last_r = 1'b0;
        n_rw0    = 1'b0;
        n_rr     = 1'b0;
        n_elig   = 1'b0;
      end else if (last_r) begin
        n_last_r = 1'b0;
        n_rr     = 1'b0;
        if (!ev_bit && !(state == ST_WDATA && rr)) begin
          n_rw0 = 1'b1;
        end else begin
          n_state = ST_IDLE;
          n_elig  = 1'b0;
        end
      end else begin
        case (state)
          ST_ADDR: begin
            n_addr = {addr[ADDR_W-2:0], ev_bit};
            n_acnt = acnt + 1'b1;
            if (acnt == ACNT_LAST) begin
              n_state  = ST_SEL;
              n_bitcnt = '0;
              n_have   = 1'b0;
            end
          end
          ST_SEL, ST_WDATA: begin
            n_state = ST_WDATA;
            n_byte  = {byte_sh[BYTE_W-3:0], ev_bit};
            if (bitcnt == BCNT_LAST) begin
              n_bitcnt = '0;
              n_addr   = {addr[ADDR_W-1:PAGE_AW], addr[PAGE_AW-1:0] + 1'b1};
              if (sel_ok) begin
                n_pg_we   = 1'b1;
                n_pg_addr = addr;
                n_pg_data = {byte_sh, ev_bit};
                n_have    = 1'b1;
              end
            end else begin
              n_bitcnt = bitcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr       <= '0;
      acnt       <= '0;
      bitcnt     <= '0;
      byte_sh    <= '0;
      have_byte  <= 1'b0;
      last_r     <= 1'b0;
      rw0        <= 1'b0;
      rr         <= 1'b0;
      elig       <= 1'b0;
      pg_we      <= 1'b0;
      pg_addr    <= '0;
      pg_data    <= '0;
      commit_req <= 1'b0;
    end else begin
      state      <= n_state;
      addr       <= n_addr;
      acnt       <= n_acnt;
      bitcnt     <= n_bitcnt;
      byte_sh    <= n_byte;
      have_byte  <= n_have;
      last_r     <= n_last_r;
      rw0        <= n_rw0;
      rr         <= n_rr;
      elig       <= n_elig;
      pg_we      <= n_pg_we;
      pg_addr    <= n_pg_addr;
      pg_data    <= n_pg_data;
      commit_req <= n_commit;
    end
  end

  // R9
  bad_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (state == ST_IDLE));

  // R4
  addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && $past(state) != ST_ADDR) |-> (acnt == '0));

  // R5
  seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && $past(state) == ST_RDATA && $past(ev_rd)
     && $past(bitcnt) == BCNT_LAST)
    |-> (addr[ARR_AW-1:0] == ARR_AW'($past(addr[ARR_AW-1:0]) + 1'b1)));

  // R11
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req);

  // R10
  load_from_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> ($past(state) == ST_WDATA && !$past(pg_we)));

  // R6
  load_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> (pg_addr[ADDR_W-1:ARR_AW] == '0));

endmodule

// File: rtl/strobe_bit_seq.sv
module strobe_bit_seq #(
  parameter int ADDR_W  = 16,
  parameter int ARR_AW  = 14,
  parameter int PAGE_AW = 5,
  parameter int BYTE_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_din,
  output logic              bus_dout,
  output logic              bus_dout_en,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [BYTE_W-1:0] arr_rdata,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [BYTE_W-1:0] pg_data,
  output logic              commit_req,
  input  logic              commit_busy
);

  localparam int PIN_W = 4;

  logic [1:0]       rst_pipe;
  logic             srst_n;
  logic [PIN_W-1:0] pins_s;
  logic             ev_rd, ev_wr, ev_bit, ev_bad;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // Line is driven only while chip-enable and output-enable are both low
  assign bus_dout_en = !bus_cs_n && !bus_rd_n;

  bcs_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({bus_cs_n, bus_rd_n, bus_wr_n, bus_din}),
    .q     (pins_s)
  );

  bcs_cycle_decode u_dec (
    .clk    (clk),
    .rst_n  (srst_n),
    .cs_n   (pins_s[3]),
    .rd_n   (pins_s[2]),
    .wr_n   (pins_s[1]),
    .din    (pins_s[0]),
    .ev_rd  (ev_rd),
    .ev_wr  (ev_wr),
    .ev_bit (ev_bit),
    .ev_bad (ev_bad)
  );

  bcs_fsm #(
    .ADDR_W (ADDR_W),
    .ARR_AW (ARR_AW),
    .PAGE_AW(PAGE_AW),
    .BYTE_W (BYTE_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .ev_rd       (ev_rd),
    .ev_wr       (ev_wr),
    .ev_bit      (ev_bit),
    .ev_bad      (ev_bad),
    .arr_rdata   (arr_rdata),
    .commit_busy (commit_busy),
    .arr_addr    (arr_addr),
    .dout        (bus_dout),
    .pg_we       (pg_we),
    .pg_addr     (pg_addr),
    .pg_data     (pg_data),
    .commit_req  (commit_req)
  );

endmodule

// File: tb/strobe_bit_seq_test.sv
module strobe_bit_seq_test;

  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, din = 1'b1;
  logic        dout, dout_en;
  logic [15:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic        pg_we, commit_req;
  logic        commit_busy = 1'b0;
  logic [15:0] pg_addr;
  logic [7:0]  pg_data;

  int nchk = 0, nfail = 0;
  int pg_n = 0, cm_n = 0;
  logic [15:0] pg_a [16];
  logic [7:0]  pg_d [16];
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction

  assign arr_rdata = mem_fn(arr_addr[13:0]);

  strobe_bit_seq uut (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_din(din),
    .bus_dout(dout), .bus_dout_en(dout_en),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .commit_req(commit_req), .commit_busy(commit_busy)
  );

  always @(negedge clk) begin
    if (pg_we && pg_n < 16) begin
      pg_a[pg_n] = pg_addr;
      pg_d[pg_n] = pg_data;
      pg_n++;
    end
    if (commit_req) cm_n++;
  end

  // Scenario table: {start address, bytes to read}
  localparam logic [23:0] SCEN [5] = '{
    {16'h0000, 8'd2}, {16'h0123, 8'd3}, {16'h3FFE, 8'd3},
    {16'h4000, 8'd1}, {16'hC07F, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic b);
    @(posedge clk); #1;
    din = b; cs_n = 1'b0; wr_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    #1; cs_n = 1'b1; wr_n = 1'b1;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic bus_rd(output logic v, output logic en);
    @(posedge clk); #1;
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    #2; v = dout; en = dout_en;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic rd_nc();
    logic v, e;
    bus_rd(v, e);
  endtask

  task automatic restart();
    rd_nc(); bus_wr(1'b0); rd_nc();
  endtask

  task automatic resync();
    bus_wr(1'b1); restart();
  endtask

  task automatic send_addr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) bus_wr(a[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_wr(b[i]);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic en_all);
    logic v, e;
    en_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bus_rd(v, e);
      b[i] = v;
      en_all = en_all & e;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic v, e, en_all;
    logic [7:0] b;
    int pg0, cm0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    chk("R1 idle dout_en", dout_en, 0);
    bus_rd(v, e);
    chk("R1 read after reset", v, 1);
    chk("R2 dout_en in read", e, 1);

    // R2: enable low during write access and with chip-enable high
    @(posedge clk); #1; din = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(posedge clk); #2;
    chk("R2 dout_en in write", dout_en, 0);
    @(posedge clk); #1; cs_n = 1'b1; wr_n = 1'b1;
    repeat (HOLD) @(posedge clk); #1; rd_n = 1'b0;
    repeat (2) @(posedge clk); #2;
    chk("R2 dout_en with cs high", dout_en, 0);
    #1 rd_n = 1'b1;
    repeat (HOLD) @(posedge clk);

    // Table-driven sequential reads (R4, R5, R6)
    for (int i = 0; i < 5; i++) begin
      logic [15:0] a;
      int nb;
      a  = SCEN[i][23:8];
      nb = int'(SCEN[i][7:0]);
      resync();
      send_addr(a);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] exp;
        logic [13:0] ak;
        ak  = a[13:0] + 14'(k);
        exp = (a[15:14] != 2'b00) ? 8'hFF : mem_fn(ak);
        read_byte(b, en_all);
        chk((a[15:14] != 2'b00) ? "R6 unselected read" :
            (k == 0) ? "R4 first byte" : "R5 sequential byte", b, exp);
      end
    end

    // R3: read after restart returns 1; then restart and read at 0x0080
    resync();
    bus_rd(v, e);
    chk("R3 read after restart", v, 1);
    bus_wr(1'b0); rd_nc();
    send_addr(16'h0080);
    read_byte(b, en_all);
    chk("R4 byte at 0080", b, 8'h25);
    chk("R2 dout_en over byte", en_all, 1);

    // R7: write 1 ends the stream (next bit would be 0)
    bus_wr(1'b1);
    bus_rd(v, e);
    chk("R7 read after end", v, 1);

    // R8: read, write 0, write 0 mid-byte goes idle
    resync(); send_addr(16'h0080);
    for (int i = 0; i < 3; i++) rd_nc();
    bus_wr(1'b0); bus_wr(1'b0);
    bus_rd(v, e);
    chk("R8 read-write-write idle", v, 1);

    // R9: all three strobes low forces idle
    resync(); send_addr(16'h0080);
    @(posedge clk); #1; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    #1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    bus_rd(v, e);
    chk("R9 collision idle", v, 1);

    // R3: restart in the middle of a read
    resync(); send_addr(16'h0080);
    for (int i = 0; i < 3; i++) rd_nc();
    restart();
    send_addr(16'h0123);
    read_byte(b, en_all);
    chk("R3 restart mid-read", b, mem_fn(14'h0123));

    // R10 / R11: page load and commit
    bus_wr(1'b1); restart();
    pg0 = pg_n; cm0 = cm_n;
    send_addr(16'h0041);
    send_byte(8'h3C); send_byte(8'hA7); send_byte(8'h01);
    chk("R10 load count", pg_n - pg0, 3);
    chk("R10 load addr0", pg_a[pg0], 16'h0041);
    chk("R10 load addr2", pg_a[pg0+2], 16'h0043);
    chk("R10 load data1", pg_d[pg0+1], 8'hA7);
    restart();
    chk("R11 commit issued", cm_n - cm0, 1);
    bus_rd(v, e);
    chk("R11 idle after commit", v, 1);

    // R10: page offset wrap
    restart();
    pg0 = pg_n;
    send_addr(16'h005F);
    send_byte(8'h11); send_byte(8'h22);
    chk("R10 wrap addr0", pg_a[pg0], 16'h005F);
    chk("R10 wrap addr1", pg_a[pg0+1], 16'h0040);
    chk("R10 wrap data1", pg_d[pg0+1], 8'h22);
    restart();
    chk("R11 second commit", cm_n - cm0, 2);

    // R11: partial byte does not commit, acts as restart
    restart();
    send_addr(16'h0000);
    send_byte(8'h55); bus_wr(1'b1); bus_wr(1'b0); bus_wr(1'b1);
    restart();
    chk("R11 partial no commit", cm_n - cm0, 2);
    send_addr(16'h0123);
    read_byte(b, en_all);
    chk("R11 partial acts as restart", b, mem_fn(14'h0123));

    // R11: no byte loaded does not commit
    resync();
    send_addr(16'h0000);
    restart();
    chk("R11 empty no commit", cm_n - cm0, 2);

    // R8: read, read, write during load goes idle
    send_addr(16'h0000);
    send_byte(8'h66);
    rd_nc(); rd_nc(); bus_wr(1'b0); rd_nc();
    chk("R8 read-read-write no commit", cm_n - cm0, 2);

    // R6: unselected address loads nothing
    bus_wr(1'b1); restart();
    pg0 = pg_n;
    send_addr(16'h8000);
    send_byte(8'h77);
    chk("R6 no load when unselected", pg_n - pg0, 0);
    restart();
    chk("R6 no commit when unselected", cm_n - cm0, 2);

    // R12: status reads follow commit_busy
    commit_busy = 1'b1;
    bus_rd(v, e);
    chk("R12 busy status", v, 0);
    commit_busy = 1'b0;
    bus_wr(1'b0); rd_nc();
    bus_rd(v, e);
    chk("R12 ready status", v, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule